// File: doc/BRIEF.md
# Deadline-Bounded Spike Key Queue

This block sits between a spike packet receiver and a row-processing engine in a time-stepped spiking network accelerator. Incoming spike keys are always captured at once into a small queue. A drain controller hands the keys to the downstream engine one at a time, waiting for the engine's done pulse before it issues the next key. Draining starts when a key lands in an empty, idle queue and continues until the queue runs dry.

Every simulation step is bounded by a step tick from the system timer. An internal cycle counter raises a deadline a fixed number of cycles before the next step tick. At the deadline, every key still queued is discarded and any key the engine is still working on is aborted, so the next step always starts on time. Keys that arrive between the deadline and the following tick are held in the queue and belong to the next step. Per-step counters are captured at each tick. A running maximum of the keys discarded in any single step is kept.

Top module: `spike_deadline_queue`

## Requirements
- R1: During reset `in_ready`, `proc_go`, `proc_abort`, all snapshot counters and `worst_flush` are 0. From the first cycle after reset `in_ready` is 1.
- R2: A key presented with `in_valid` while the queue is not full is stored. Keys reach `proc_key` in arrival order, each marked by a one-cycle `proc_go` pulse, with `proc_key` valid while `proc_go` is high.
- R3: At most one key is outstanding. After `proc_go`, no new key is issued until `proc_done` is seen. If the queue is not empty in that cycle, the next `proc_go` follows in the next cycle. Each `proc_done` for an outstanding key counts as one processed key.
- R4: The start count of a step counts only issues made while no key was outstanding, not back-to-back issues.
- R5: The deadline occurs STEP_CYC-LEAD cycles after the last step tick (or after reset). In that cycle all queued keys are discarded. An outstanding key without `proc_done` in that cycle is aborted, and `proc_abort` pulses for one cycle in the next cycle. The flushed count of the step is the number of queued keys plus the aborted key.
- R6: From the deadline until the next step tick, no key is issued. Keys written in that window are kept, not flushed, issued after the tick, and counted as received in the following step.
- R7: A key offered while the queue holds DEPTH keys is not stored and is counted as dropped. It is not counted as received.
- R8: At each step tick, the received, processed, flushed, dropped, start and zero-target counts of the step just ended appear on the `snap_*` outputs. When a deadline occurred in that step, received equals processed plus flushed.
- R9: A `proc_done` with `proc_zero` high counts as one zero-target key in the current step.
- R10: `worst_flush` holds the largest per-step flushed count seen since reset and never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_tick | input | 1 | One-cycle pulse marking a step boundary |
| in_key | input | KEY_W | Incoming spike key |
| in_valid | input | 1 | `in_key` is valid |
| in_ready | output | 1 | Capture path is ready |
| proc_key | output | KEY_W | Key handed to the row engine |
| proc_go | output | 1 | One-cycle pulse: `proc_key` is issued |
| proc_done | input | 1 | Engine finished the outstanding key |
| proc_zero | input | 1 | With `proc_done`: key matched no targets |
| proc_abort | output | 1 | Outstanding key was cancelled by the deadline |
| snap_recv | output | CNT_W | Keys received in the last step |
| snap_proc | output | CNT_W | Keys processed in the last step |
| snap_flush | output | CNT_W | Keys flushed in the last step |
| snap_drop | output | CNT_W | Keys dropped on a full queue in the last step |
| snap_starts | output | CNT_W | Starts from idle in the last step |
| snap_zero | output | CNT_W | Zero-target keys in the last step |
| worst_flush | output | CNT_W | Largest per-step flushed count since reset |

## Verification
The main function is driven with one stimulus pattern per step. The patterns are: a short burst with a fast engine, which shows back-to-back draining and a single start; keys spaced far apart, which must produce two starts; a slow engine that is still busy at the deadline, which separates aborted keys from queued ones in the flush count; and an oversized burst into a full queue, which separates dropped keys from flushed ones. An empty step confirms that all counts return to zero while the worst flush count is kept. Directed tests cover reset values and a key sent after the deadline, which must stay unissued until the tick and then show up in the next step's received and processed counts.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  typedef enum logic {
    DR_IDLE = 1'b0,
    DR_BUSY = 1'b1
  } drain_state_e;

  localparam int SDQ_MIN_DEPTH = 2;
endpackage

// File: rtl/sdq_step_timer.sv
module sdq_step_timer #(
  parameter int STEP_CYC = 20000,
  parameter int LEAD     = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic step_tick,
  output logic deadline,
  output logic closed
);
  localparam int DL_AT = STEP_CYC - LEAD;
  localparam int CW    = $clog2(STEP_CYC + 1);

  logic [CW-1:0] cyc;

  // cycles since the last tick, saturating at one full step
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc    <= '0;
      closed <= 1'b0;
    end else if (step_tick) begin
      cyc    <= '0;
      closed <= 1'b0;
    end else begin
      if (cyc != CW'(STEP_CYC)) cyc <= cyc + 1'b1;
      if (deadline) closed <= 1'b1;
    end
  end

  assign deadline = (cyc == CW'(DL_AT)) && !closed && !step_tick;

  p_one_deadline_r5: assert property (@(posedge clk) disable iff (rst)
    deadline |=> !deadline);
endmodule

// File: rtl/sdq_key_fifo.sv
module sdq_key_fifo #(
  parameter int KEY_W = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             pop,
  input  logic             flush,
  output logic [KEY_W-1:0] rd_key,
  output logic [AW:0]      level,
  output logic             full,
  output logic             empty
);
  logic [KEY_W-1:0] mem [DEPTH];
  logic [AW:0]      wr_ptr;
  logic [AW:0]      rd_ptr;

  // storage without reset and with a registered read port
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_key;
    if (pop)   rd_key <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (flush)    rd_ptr <= wr_ptr;
      else if (pop) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign level = wr_ptr - rd_ptr;
  assign full  = (level == (AW+1)'(DEPTH));
  assign empty = (level == '0);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    full |-> !wr_en);
  p_flush_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (flush && !wr_en) |=> empty);
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);
endmodule

// File: rtl/sdq_drain_ctrl.sv
module sdq_drain_ctrl
  import sdq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic empty,
  input  logic closed,
  input  logic deadline,
  input  logic proc_done,
  output logic pop,
  output logic proc_go,
  output logic proc_abort,
  output logic start_ev,
  output logic done_ev,
  output logic abort_ev
);
  drain_state_e state;
  logic         inflight;

  assign inflight = (state == DR_BUSY);
  assign done_ev  = inflight && proc_done;
  assign abort_ev = deadline && inflight && !proc_done;
  assign pop      = (!inflight || proc_done) && !empty && !closed && !deadline;
  assign start_ev = pop && !inflight;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= DR_IDLE;
      proc_go    <= 1'b0;
      proc_abort <= 1'b0;
    end else begin
      proc_go    <= pop;
      proc_abort <= abort_ev;
      if (deadline)     state <= DR_IDLE;
      else if (pop)     state <= DR_BUSY;
      else if (done_ev) state <= DR_IDLE;
    end
  end

  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (rst)
    (inflight && !proc_done) |=> !proc_go);
  p_closed_no_issue_r6: assert property (@(posedge clk) disable iff (rst)
    closed |=> !proc_go);
  p_abort_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    (deadline && inflight && !proc_done) |=> proc_abort);
endmodule

// File: rtl/sdq_step_stats.sv
module sdq_step_stats #(
  parameter int CNT_W = 16,
  parameter int FW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_tick,
  input  logic             closed,
  input  logic             win_shut,
  input  logic             deadline,
  input  logic             wr_ev,
  input  logic             drop_ev,
  input  logic             done_ev,
  input  logic             zero_ev,
  input  logic             start_ev,
  input  logic [FW-1:0]    flush_n,
  output logic [CNT_W-1:0] snap_recv,
  output logic [CNT_W-1:0] snap_proc,
  output logic [CNT_W-1:0] snap_flush,
  output logic [CNT_W-1:0] snap_drop,
  output logic [CNT_W-1:0] snap_starts,
  output logic [CNT_W-1:0] snap_zero,
  output logic [CNT_W-1:0] worst_flush
);
  localparam int NCNT = 5;
  localparam int I_PROC = 0, I_DROP = 1, I_START = 2, I_ZERO = 3, I_PEND = 4;

  logic [CNT_W-1:0] recv_c, flush_c;
  logic [CNT_W-1:0] cnt [NCNT];
  logic [NCNT-1:0]  ev;
  logic [CNT_W-1:0] flush_w;

  assign ev[I_PROC]  = done_ev;
  assign ev[I_DROP]  = drop_ev;
  assign ev[I_START] = start_ev;
  assign ev[I_ZERO]  = zero_ev;
  assign ev[I_PEND]  = wr_ev && win_shut;
  assign flush_w     = CNT_W'(flush_n);

  // simple event counters; events in the tick cycle open the new step
  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)            cnt[g] <= '0;
      else if (step_tick && g != I_PEND) cnt[g] <= CNT_W'(ev[g]);
      else if (step_tick) cnt[g] <= '0;
      else if (ev[g])     cnt[g] <= cnt[g] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      recv_c      <= '0;
      flush_c     <= '0;
      snap_recv   <= '0;
      snap_proc   <= '0;
      snap_flush  <= '0;
      snap_drop   <= '0;
      snap_starts <= '0;
      snap_zero   <= '0;
      worst_flush <= '0;
    end else begin
      if (step_tick) begin
        snap_recv   <= recv_c;
        snap_proc   <= cnt[I_PROC];
        snap_flush  <= flush_c;
        snap_drop   <= cnt[I_DROP];
        snap_starts <= cnt[I_START];
        snap_zero   <= cnt[I_ZERO];
        recv_c      <= cnt[I_PEND] + CNT_W'(wr_ev);
        flush_c     <= '0;
      end else begin
        if (wr_ev && !win_shut) recv_c <= recv_c + 1'b1;
        if (deadline) flush_c <= flush_w;
      end
      if (deadline && flush_w > worst_flush) worst_flush <= flush_w;
    end
  end

  p_balance_r8: assert property (@(posedge clk) disable iff (rst)
    (step_tick && closed) |-> (recv_c == cnt[I_PROC] + flush_c));
  p_worst_mono_r10: assert property (@(posedge clk) disable iff (rst)
    worst_flush >= $past(worst_flush));
endmodule

// File: rtl/spike_deadline_queue.sv
module spike_deadline_queue #(
  parameter int KEY_W    = 32,
  parameter int DEPTH    = 16,
  parameter int CNT_W    = 16,
  parameter int STEP_CYC = 20000,
  parameter int LEAD     = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_tick,
  input  logic [KEY_W-1:0] in_key,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [KEY_W-1:0] proc_key,
  output logic             proc_go,
  input  logic             proc_done,
  input  logic             proc_zero,
  output logic             proc_abort,
  output logic [CNT_W-1:0] snap_recv,
  output logic [CNT_W-1:0] snap_proc,
  output logic [CNT_W-1:0] snap_flush,
  output logic [CNT_W-1:0] snap_drop,
  output logic [CNT_W-1:0] snap_starts,
  output logic [CNT_W-1:0] snap_zero,
  output logic [CNT_W-1:0] worst_flush
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = AW + 2;

  logic          deadline, closed, win_shut;
  logic          full, empty, wr_ev, drop_ev;
  logic          pop, start_ev, done_ev, abort_ev;
  logic [AW:0]   level;
  logic [FW-1:0] flush_n;

  always_ff @(posedge clk) begin
    if (rst) in_ready <= 1'b0;
    else     in_ready <= 1'b1;
  end

  assign wr_ev    = in_valid && in_ready && !full;
  assign drop_ev  = in_valid && in_ready && full;
  assign win_shut = closed || deadline;
  assign flush_n  = FW'(level) + FW'(abort_ev);

  sdq_step_timer #(.STEP_CYC(STEP_CYC), .LEAD(LEAD)) u_timer (
    .clk(clk), .rst(rst), .step_tick(step_tick),
    .deadline(deadline), .closed(closed)
  );

  sdq_key_fifo #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_ev), .wr_key(in_key),
    .pop(pop), .flush(deadline), .rd_key(proc_key),
    .level(level), .full(full), .empty(empty)
  );

  sdq_drain_ctrl u_drain (
    .clk(clk), .rst(rst), .empty(empty), .closed(closed),
    .deadline(deadline), .proc_done(proc_done), .pop(pop),
    .proc_go(proc_go), .proc_abort(proc_abort), .start_ev(start_ev),
    .done_ev(done_ev), .abort_ev(abort_ev)
  );

  sdq_step_stats #(.CNT_W(CNT_W), .FW(FW)) u_stats (
    .clk(clk), .rst(rst), .step_tick(step_tick), .closed(closed),
    .win_shut(win_shut), .deadline(deadline), .wr_ev(wr_ev),
    .drop_ev(drop_ev), .done_ev(done_ev), .zero_ev(done_ev && proc_zero),
    .start_ev(start_ev), .flush_n(flush_n),
    .snap_recv(snap_recv), .snap_proc(snap_proc), .snap_flush(snap_flush),
    .snap_drop(snap_drop), .snap_starts(snap_starts), .snap_zero(snap_zero),
    .worst_flush(worst_flush)
  );

  initial begin
    p_depth_ok_r7: assert (DEPTH >= sdq_pkg::SDQ_MIN_DEPTH && (1 << AW) == DEPTH);
    p_lead_ok_r5:  assert (LEAD > 0 && LEAD < STEP_CYC);
  end
endmodule

// File: tb/spike_deadline_queue_tb.sv
module spike_deadline_queue_tb_top;
  localparam int KEY_W = 16, DEPTH = 4, CNT_W = 8, STEP_CYC = 64, LEAD = 16;
  localparam int NV = 6;
  // per step: keys, engine latency, gap between keys, zero mask, order check
  localparam int V_N  [NV] = '{3, 2, 6, 4, 2, 0};
  localparam int V_LAT[NV] = '{2, 100, 100, 1, 2, 2};
  localparam int V_GAP[NV] = '{0, 0, 0, 0, 20, 0};
  localparam int V_ZM [NV] = '{2, 0, 0, 15, 0, 0};
  localparam int V_ORD[NV] = '{1, 0, 0, 1, 1, 0};
  // expected snapshot: recv, proc, flush, drop, starts, zero, worst, aborts
  localparam int E_RCV[NV] = '{3, 2, 5, 4, 2, 0};
  localparam int E_PRC[NV] = '{3, 0, 0, 4, 2, 0};
  localparam int E_FLS[NV] = '{0, 2, 5, 0, 0, 0};
  localparam int E_DRP[NV] = '{0, 0, 1, 0, 0, 0};
  localparam int E_STA[NV] = '{1, 1, 1, 1, 2, 0};
  localparam int E_ZER[NV] = '{1, 0, 0, 4, 0, 0};
  localparam int E_WST[NV] = '{0, 2, 5, 5, 5, 5};
  localparam int E_ABT[NV] = '{0, 1, 1, 0, 0, 0};

  logic clk = 0, rst = 1, step_tick = 0, in_valid = 0, proc_done = 0, proc_zero = 0;
  logic [KEY_W-1:0] in_key = '0;
  logic in_ready, proc_go, proc_abort;
  logic [KEY_W-1:0] proc_key;
  logic [CNT_W-1:0] s_rcv, s_prc, s_fls, s_drp, s_sta, s_zer, worst;

  int checks = 0, fails = 0, tcnt = 0;
  int cur_lat = 2, cur_zm = 0, go_idx = 0, go_cnt = 0, aborts = 0;
  int m_wait = 0, m_cnt = 0, m_zero = 0, ord_on = 0, hd = 0, tl = 0;
  logic [KEY_W-1:0] exp_q [64];
  bit finished = 0;

  always #4 clk = ~clk;

  spike_deadline_queue #(.KEY_W(KEY_W), .DEPTH(DEPTH), .CNT_W(CNT_W),
    .STEP_CYC(STEP_CYC), .LEAD(LEAD)) dut_i (
    .clk(clk), .rst(rst), .step_tick(step_tick), .in_key(in_key),
    .in_valid(in_valid), .in_ready(in_ready), .proc_key(proc_key),
    .proc_go(proc_go), .proc_done(proc_done), .proc_zero(proc_zero),
    .proc_abort(proc_abort), .snap_recv(s_rcv), .snap_proc(s_prc),
    .snap_flush(s_fls), .snap_drop(s_drp), .snap_starts(s_sta),
    .snap_zero(s_zer), .worst_flush(worst));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial forever begin
    @(posedge clk);
    tcnt = step_tick ? 0 : tcnt + 1;
  end

  // downstream row engine model
  initial forever begin
    @(negedge clk);
    proc_done = 0; proc_zero = 0;
    if (proc_abort) begin aborts++; m_wait = 0; end
    else if (m_wait != 0) begin
      if (m_cnt == 0) begin proc_done = 1; proc_zero = m_zero[0]; m_wait = 0; end
      else m_cnt--;
    end
    if (proc_go) begin
      go_cnt++;
      if (m_wait != 0) chk("R3 issue while outstanding", 1, 0);
      m_wait = 1; m_cnt = cur_lat - 1; m_zero = (cur_zm >> (go_idx % 8)) & 1; go_idx++;
      if (ord_on != 0) begin
        chk("R2 key order", int'(proc_key), int'(exp_q[hd % 64])); hd++;
      end
    end
  end

  task automatic tick();
    @(negedge clk); step_tick = 1;
    @(negedge clk); step_tick = 0;
  endtask

  task automatic send(input int n, input int gap, input int id);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); in_valid = 1; in_key = {8'(id), 8'(k)};
      if (ord_on != 0) begin exp_q[tl % 64] = in_key; tl++; end
      if (gap > 0) begin @(negedge clk); in_valid = 0; repeat (gap - 1) @(negedge clk); end
    end
    @(negedge clk); in_valid = 0;
  endtask

  task automatic wait_end();
    while (tcnt < 60) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    int go_before;
    repeat (3) @(negedge clk);
    chk("R1 in_ready in reset", int'(in_ready), 0);
    chk("R1 proc_go in reset", int'(proc_go), 0);
    chk("R1 worst in reset", int'(worst), 0);
    chk("R1 snap_recv in reset", int'(s_rcv), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 in_ready after reset", int'(in_ready), 1);
    chk("R1 proc_abort after reset", int'(proc_abort), 0);
    tick();
    for (int v = 0; v < NV; v++) begin
      int ab0;
      cur_lat = V_LAT[v]; cur_zm = V_ZM[v]; go_idx = 0; ord_on = V_ORD[v];
      ab0 = aborts;
      send(V_N[v], V_GAP[v], v);
      wait_end();
      tick();
      chk("R8 received", int'(s_rcv), E_RCV[v]);
      chk("R3 processed", int'(s_prc), E_PRC[v]);
      chk("R5 flushed", int'(s_fls), E_FLS[v]);
      chk("R7 dropped", int'(s_drp), E_DRP[v]);
      chk("R4 starts", int'(s_sta), E_STA[v]);
      chk("R9 zero-target", int'(s_zer), E_ZER[v]);
      chk("R10 worst flush", int'(worst), E_WST[v]);
      chk("R5 abort pulses", aborts - ab0, E_ABT[v]);
    end
    // R6: a key sent after the deadline is held for the next step
    cur_lat = 2; cur_zm = 0; go_idx = 0; ord_on = 1;
    while (tcnt < 52) @(negedge clk);
    go_before = go_cnt;
    send(1, 0, 8'hA5);
    wait_end();
    chk("R6 no issue after deadline", go_cnt - go_before, 0);
    tick();
    chk("R6 held key not received in its own step", int'(s_rcv), 0);
    chk("R6 held key not flushed", int'(s_fls), 0);
    wait_end();
    chk("R6 held key issued after tick", go_cnt - go_before, 1);
    tick();
    chk("R6 held key received next step", int'(s_rcv), 1);
    chk("R6 held key processed next step", int'(s_prc), 1);
    chk("R4 held key start", int'(s_sta), 1);
    chk("R10 worst kept", int'(worst), 5);
    finished = 1;
    finish_run();
  end
endmodule